// File: doc/BRIEF.md
# Erase-Tolerant Flash ECC Codec

This block protects a 72-bit flash storage word, made of 64 data bits and 8 check bits, with a single-error-correcting, double-error-detecting code. The code is shaped for flash behaviour. A freshly erased location reads back as all ones, and that word is a valid codeword. Each 16-bit half-word of the data can later be programmed from all ones to all zeros while the check byte stays at 0xFF. A word can therefore be written several times between erases, for example to hold flags, and a blank check after an erase is just an ordinary ECC read.

The encode path is combinational. It turns a 64-bit data word into its 8 check bits. The decode path registers its results one cycle after a read strobe. It returns the corrected data together with a flag for a corrected single error, a flag for an uncorrectable error and a flag for a blank (fully erased) word. Each of the 64 data bits has its own syndrome column, computed when the design is elaborated. The columns are 32 weight-3 patterns and their complements, paired up inside each half-word so that every half-word's columns XOR to zero.

Top module: `ecc_flash_codec`

## Requirements
- R1: When all 64 encoder data bits are 1, the encoder outputs check byte 0xFF.
- R2: Each 16-bit half-word (data bits [16h+15:16h], h = 0..3) may be all ones or all zeros. For all 16 such combinations, including all-zero data, the check byte is 0xFF.
- R3: A read of 72 one bits (data all ones, check 0xFF) returns data all ones, with the corrected flag 0, the uncorrectable flag 0 and the blank flag 1.
- R4: The blank flag is 1 only when every one of the 72 raw stored bits is 1. If any single bit is 0, the blank flag is 0.
- R5: A read of a data word together with its own encoded check byte returns that data unchanged, with both error flags 0.
- R6: If any one of the 64 stored data bits is inverted, the read returns the original data, with the corrected flag 1 and the uncorrectable flag 0.
- R7: If any one of the 8 stored check bits is inverted, the read returns the stored data unchanged, with the corrected flag 1 and the uncorrectable flag 0.
- R8: If any two distinct bits of the 72 are inverted, the uncorrectable flag is 1 and the corrected flag is 0. The two flags are never 1 together.
- R9: The read-valid output equals the read-valid input of the previous clock edge, and the decode results belong to that read.
- R10: In a cycle with no read strobe, the data and flag outputs keep their values.
- R11: While the synchronous active-low reset is low, the read-valid output, the data output and all three flags are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| enc_data_i | input | 64 | Data word to encode |
| enc_check_o | output | 8 | Check byte for enc_data_i (combinational) |
| rd_valid_i | input | 1 | Read strobe for the stored word below |
| rd_data_i | input | 64 | Stored data bits |
| rd_check_i | input | 8 | Stored check bits |
| rd_valid_o | output | 1 | Decode results valid |
| rd_data_o | output | 64 | Corrected data |
| rd_sec_o | output | 1 | A single error was corrected |
| rd_ded_o | output | 1 | An uncorrectable (double) error was found |
| rd_blank_o | output | 1 | All 72 stored bits were 1 |

## Verification
The properties assume that reset is held low for at least one clock edge before the first read, and that the strobe and stored bits are known at every rising edge. The bench meets this by driving every input from reset onward and by changing inputs only on falling edges. The flag properties hold for any input. The meaning of the flags, however, is only defined for at most two inverted bits. The stimulus therefore injects clean words, single flips and double flips only, and never three or more errors in one word.

// File: rtl/ecc_rw_pkg.sv
package ecc_rw_pkg;
   parameter int DATA_W_DEF = 64;
   parameter int CHK_W_DEF  = 8;
   parameter int HALF_W_DEF = 16;

   // Syndrome column of data bit idx. Even bits take the (idx/2)-th
   // weight-3 pattern in ascending order, odd bits take its complement,
   // so each adjacent pair XORs to all ones and any even-sized group of
   // pairs XORs to zero.
   function automatic logic [15:0] column_code(int unsigned idx, int unsigned cw);
      int unsigned want;
      int unsigned seen;
      logic [15:0] r;
      logic [16:0] m;
      want = idx / 2;
      seen = 0;
      r    = '0;
      m    = (17'h1 << cw) - 17'h1;
      for (int unsigned x = 0; x < (32'd1 << cw); x++) begin
         if ($countones(x[15:0]) == 3) begin
            if (seen == want) r = x[15:0];
            seen++;
         end
      end
      if (idx[0]) r = ~r & m[15:0];
      return r;
   endfunction
endpackage

// File: rtl/ecc_check_gen.sv
module ecc_check_gen #(
   parameter int DATA_W = ecc_rw_pkg::DATA_W_DEF,
   parameter int CHK_W  = ecc_rw_pkg::CHK_W_DEF
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CHK_W-1:0]  check_o
);
   logic [CHK_W-1:0] col [DATA_W];

   for (genvar i = 0; i < DATA_W; i++) begin : g_col
      assign col[i] = CHK_W'(ecc_rw_pkg::column_code(i, CHK_W));
   end

   // Constant term of all ones; the column sum over all data is zero.
   always_comb begin
      check_o = '1;
      for (int i = 0; i < DATA_W; i++) begin
         if (data_i[i]) check_o = check_o ^ col[i];
      end
   end
endmodule

// File: rtl/ecc_syndrome_locate.sv
module ecc_syndrome_locate #(
   parameter int DATA_W = ecc_rw_pkg::DATA_W_DEF,
   parameter int CHK_W  = ecc_rw_pkg::CHK_W_DEF
) (
   input  logic [CHK_W-1:0]  syn_i,
   output logic [DATA_W-1:0] flip_o,
   output logic              sec_o,
   output logic              ded_o
);
   logic chk_hit;

   for (genvar i = 0; i < DATA_W; i++) begin : g_match
      assign flip_o[i] = (syn_i == CHK_W'(ecc_rw_pkg::column_code(i, CHK_W)));
   end

   assign chk_hit = $onehot(syn_i);
   assign sec_o   = (|flip_o) | chk_hit;
   assign ded_o   = (|syn_i) & ~sec_o;
endmodule

// File: rtl/ecc_flash_codec.sv
module ecc_flash_codec #(
   parameter int DATA_W = ecc_rw_pkg::DATA_W_DEF,
   parameter int CHK_W  = ecc_rw_pkg::CHK_W_DEF,
   parameter int HALF_W = ecc_rw_pkg::HALF_W_DEF
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] enc_data_i,
   output logic [CHK_W-1:0]  enc_check_o,
   input  logic              rd_valid_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic [CHK_W-1:0]  rd_check_i,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_sec_o,
   output logic              rd_ded_o,
   output logic              rd_blank_o
);
   localparam int NUM_W3 = CHK_W * (CHK_W - 1) * (CHK_W - 2) / 6;

   if (HALF_W % 2 != 0) begin : g_bad_half
      $fatal(1, "half-word width must be even");
   end
   if (DATA_W % HALF_W != 0) begin : g_bad_split
      $fatal(1, "data width must be a multiple of the half-word width");
   end
   if (CHK_W < 4 || CHK_W > 15) begin : g_bad_chk
      $fatal(1, "check width out of range");
   end
   if (NUM_W3 < DATA_W / 2) begin : g_few_cols
      $fatal(1, "not enough weight-3 columns for the data width");
   end

   logic [CHK_W-1:0]  recalc;
   logic [CHK_W-1:0]  syn;
   logic [DATA_W-1:0] flip;
   logic              sec_c, ded_c, blank_c;

   ecc_check_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) enc_u (
      .data_i (enc_data_i),
      .check_o(enc_check_o)
   );

   ecc_check_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) recalc_u (
      .data_i (rd_data_i),
      .check_o(recalc)
   );

   assign syn = recalc ^ rd_check_i;

   ecc_syndrome_locate #(.DATA_W(DATA_W), .CHK_W(CHK_W)) locate_u (
      .syn_i (syn),
      .flip_o(flip),
      .sec_o (sec_c),
      .ded_o (ded_c)
   );

   assign blank_c = &{rd_check_i, rd_data_i};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
         rd_sec_o   <= 1'b0;
         rd_ded_o   <= 1'b0;
         rd_blank_o <= 1'b0;
      end else begin
         rd_valid_o <= rd_valid_i;
         if (rd_valid_i) begin
            rd_data_o  <= rd_data_i ^ flip;
            rd_sec_o   <= sec_c;
            rd_ded_o   <= ded_c;
            rd_blank_o <= blank_c;
         end
      end
   end
endmodule

// File: rtl/ecc_flash_codec_chk.sv
module ecc_flash_codec_chk #(
   parameter int DATA_W = ecc_rw_pkg::DATA_W_DEF,
   parameter int CHK_W  = ecc_rw_pkg::CHK_W_DEF,
   parameter int HALF_W = ecc_rw_pkg::HALF_W_DEF
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [DATA_W-1:0] enc_data_i,
   input logic [CHK_W-1:0]  enc_check_o,
   input logic              rd_valid_i,
   input logic [DATA_W-1:0] rd_data_i,
   input logic [CHK_W-1:0]  rd_check_i,
   input logic              rd_valid_o,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              rd_sec_o,
   input logic              rd_ded_o,
   input logic              rd_blank_o
);
   localparam int NUM_HALF = DATA_W / HALF_W;

   logic hw_pattern;
   always_comb begin
      hw_pattern = 1'b1;
      for (int h = 0; h < NUM_HALF; h++) begin
         if (!((&enc_data_i[h*HALF_W +: HALF_W]) || !(|enc_data_i[h*HALF_W +: HALF_W])))
            hw_pattern = 1'b0;
      end
   end

   assert_enc_erased_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&enc_data_i) |-> (&enc_check_o));

   assert_enc_halfword_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_pattern |-> (&enc_check_o));

   assert_blank_clean_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_blank_o |-> (!rd_sec_o && !rd_ded_o));

   assert_blank_raw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && rd_valid_o) |-> (rd_blank_o == $past(&{rd_check_i, rd_data_i})));

   assert_flag_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd_sec_o && rd_ded_o));

   assert_valid_delay_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (rd_valid_o == $past(rd_valid_i)));

   assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !rd_valid_o) |->
         ($stable(rd_data_o) && $stable(rd_sec_o) && $stable(rd_ded_o) && $stable(rd_blank_o)));
endmodule

bind ecc_flash_codec ecc_flash_codec_chk #(
   .DATA_W(DATA_W), .CHK_W(CHK_W), .HALF_W(HALF_W)
) chk_i (.*);

// File: tb/ecc_flash_codec_tb_top.sv
`timescale 1ns/1ps
module ecc_flash_codec_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [63:0] enc_data;
   logic [7:0]  enc_check;
   logic        rd_valid_i;
   logic [63:0] rd_data_i;
   logic [7:0]  rd_check_i;
   logic        rd_valid_o;
   logic [63:0] rd_data_o;
   logic        rd_sec_o, rd_ded_o, rd_blank_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [63:0] data;
      bit          cmp_data;
      logic        sec;
      logic        ded;
      logic        blank;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   ecc_flash_codec dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .enc_data_i(enc_data), .enc_check_o(enc_check),
      .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .rd_check_i(rd_check_i),
      .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
      .rd_sec_o(rd_sec_o), .rd_ded_o(rd_ded_o), .rd_blank_o(rd_blank_o)
   );

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic get_check(input logic [63:0] d, output logic [7:0] c);
      enc_data = d;
      #0.1;
      c = enc_check;
   endtask

   task automatic send(input logic [63:0] d, input logic [7:0] c, input logic [63:0] ed,
                       input bit cmpd, input logic es, input logic edd, input logic eb,
                       input string tag);
      exp_t e;
      @(negedge clk);
      rd_data_i  = d;
      rd_check_i = c;
      rd_valid_i = 1'b1;
      e.data = ed; e.cmp_data = cmpd; e.sec = es; e.ded = edd; e.blank = eb; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         rd_valid_i = 1'b0;
      end
   endtask

   // Monitor: scoreboard comparison one cycle after each strobe.
   always @(negedge clk) begin
      if (rst_n && rd_valid_o) begin
         if (sb.size() == 0) begin
            check(1'b0, "R9", "valid without pending read", 64'(rd_valid_o), 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (e.cmp_data)
               check(rd_data_o === e.data, e.tag, "data", rd_data_o, e.data);
            check({rd_sec_o, rd_ded_o, rd_blank_o} === {e.sec, e.ded, e.blank}, e.tag,
                  "flags sec/ded/blank", 64'({rd_sec_o, rd_ded_o, rd_blank_o}),
                  64'({e.sec, e.ded, e.blank}));
         end
      end
   end

   initial begin
      #(200000 * 5);
      check(1'b0, "watchdog", "run did not finish", 64'd0, 64'd1);
      finish_run();
   end

   initial begin
      logic [63:0] pats [6];
      logic [7:0]  c;
      logic [63:0] hold_d;
      logic [2:0]  hold_f;

      pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[1] = 64'h0123_4567_89AB_CDEF;
      pats[2] = 64'h0000_0000_0000_0000;
      pats[3] = 64'hDEAD_BEEF_5A5A_C3C3;
      pats[4] = 64'h8000_0000_0000_0001;
      pats[5] = 64'hFFFF_0000_1234_FFFF;

      rst_n = 1'b0; rd_valid_i = 1'b1; rd_data_i = '1; rd_check_i = '1; enc_data = '0;
      repeat (4) @(negedge clk);
      // R11: reset clears outputs even with a strobe present
      check({rd_valid_o, rd_sec_o, rd_ded_o, rd_blank_o} === 4'b0, "R11", "reset flags",
            64'({rd_valid_o, rd_sec_o, rd_ded_o, rd_blank_o}), 64'd0);
      check(rd_data_o === 64'd0, "R11", "reset data", rd_data_o, 64'd0);
      rd_valid_i = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(rd_valid_o === 1'b0, "R9", "no strobe no valid", 64'(rd_valid_o), 64'd0);

      // R1 and R2: every half-word zeroing combination
      get_check(64'hFFFF_FFFF_FFFF_FFFF, c);
      check(c === 8'hFF, "R1", "erased data check", 64'(c), 64'hFF);
      for (int m = 0; m < 16; m++) begin
         logic [63:0] d;
         for (int h = 0; h < 4; h++) d[h*16 +: 16] = m[h] ? 16'h0000 : 16'hFFFF;
         get_check(d, c);
         check(c === 8'hFF, "R2", "half-word pattern check", 64'(c), 64'hFF);
      end

      // R3: erased word
      send(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b1, "R3");

      // R5: clean codewords
      for (int p = 1; p < 6; p++) begin
         get_check(pats[p], c);
         send(pats[p], c, pats[p], 1'b1, 1'b0, 1'b0, 1'b0, "R5");
      end

      // R6 (and R4 on the erased base): single data-bit flips
      for (int p = 0; p < 4; p++) begin
         get_check(pats[p], c);
         for (int i = 0; i < 64; i++)
            send(pats[p] ^ (64'd1 << i), c, pats[p], 1'b1, 1'b1, 1'b0, 1'b0,
                 (p == 0) ? "R4" : "R6");
      end

      // R7 (and R4 on the erased base): single check-bit flips
      for (int p = 0; p < 4; p++) begin
         get_check(pats[p], c);
         for (int j = 0; j < 8; j++)
            send(pats[p], c ^ (8'd1 << j), pats[p], 1'b1, 1'b1, 1'b0, 1'b0,
                 (p == 0) ? "R4" : "R7");
      end
      idle(1);

      // R8: sampled double flips over the 72-bit word
      for (int p = 0; p < 4; p++) begin
         get_check(pats[p], c);
         for (int i = 0; i < 72; i++) begin
            int j;
            logic [71:0] w;
            j = (i * 29 + 11) % 72;
            if (j != i) begin
               w = {c, pats[p]} ^ (72'd1 << i) ^ (72'd1 << j);
               send(w[63:0], w[71:64], pats[p], 1'b0, 1'b0, 1'b1, 1'b0, "R8");
            end
         end
      end

      // R10: outputs hold while no strobe
      get_check(pats[5], c);
      send(pats[5] ^ 64'h10, c, pats[5], 1'b1, 1'b1, 1'b0, 1'b0, "R6");
      idle(1);
      hold_d = rd_data_o;
      hold_f = {rd_sec_o, rd_ded_o, rd_blank_o};
      rd_data_i = 64'hFFFF_FFFF_FFFF_FFFF;
      rd_check_i = 8'hFF;
      idle(3);
      check(rd_data_o === hold_d, "R10", "data hold", rd_data_o, hold_d);
      check({rd_sec_o, rd_ded_o, rd_blank_o} === hold_f, "R10", "flags hold",
            64'({rd_sec_o, rd_ded_o, rd_blank_o}), 64'(hold_f));
      check(rd_valid_o === 1'b0, "R9", "valid low after idle", 64'(rd_valid_o), 64'd0);

      idle(3);
      check(sb.size() == 0, "R9", "every read answered", 64'(sb.size()), 64'd0);
      finish_run();
   end
endmodule